// File: doc/BRIEF.md
# Instruction Decode Control Unit

This block turns one 32-bit instruction word into the control bundle a small load/store pipeline needs in its decode stage. It looks at the 6-bit opcode in bits 31:26. For register-format words it also looks at the 6-bit function field in bits 5:0. From these two fields it produces the register-write enable and the destination choice. It also produces the ALU operand source, a 3-bit ALU operation, the memory read and write strobes, the write-back source, and the branch and jump flags.

Any encoding outside the supported set raises an illegal flag. That same flag forces every control output to zero, so an unknown word can never write state. The block also sign-extends the low 16 bits of the word to 32 bits for the immediate operand path.

The decoder is purely combinational. It sits between the fetch/decode pipeline register and the register-file read stage. The register fields (bits 25:6) pass to the datapath around it and have no effect on the decode.

Top module: `instr_ctrl_decode`

## Requirements
- R1: Opcode 000000 with a supported function code sets reg_write=1, reg_dst_rd=1, alu_src_imm=0, and mem_read, mem_write, mem_to_reg, branch, jump all 0.
- R2: For opcode 000000 the ALU code follows the function field: 110000 add=000, 110001 sub=001, 110010 and=010, 110011 or=011, 110100 nor=100, 110101 sll=101, 110110 srl=110.
- R3: Opcodes 001000, 001001 and 001010 set reg_write=1, reg_dst_rd=0, alu_src_imm=1, no memory, branch or jump, and ALU code add=000, and=010, or=011 respectively.
- R4: Opcode 010000 (load) sets reg_write=1, reg_dst_rd=0, alu_src_imm=1, mem_read=1, mem_to_reg=1, ALU code 000, and mem_write, branch, jump all 0.
- R5: Opcode 010001 (store) sets mem_write=1, alu_src_imm=1, ALU code 000, and reg_write, reg_dst_rd, mem_read, mem_to_reg, branch, jump all 0.
- R6: Opcode 000100 (branch on equal) sets branch=1, ALU code 001, alu_src_imm=0, and every other control output 0.
- R7: Opcode 000010 (jump) sets jump=1, ALU code 000, and every other control output 0.
- R8: Any other opcode, or opcode 000000 with a function code other than 110000 to 110110, sets illegal=1 and drives every control output, including the ALU code, to 0. For every legal word, illegal=0.
- R9: imm_ext equals bits 15:0 of the instruction, sign-extended from bit 15, for every instruction word.
- R10: Bits 25:6 of the instruction have no effect on any control output or on illegal.
- R11: At most one of mem_read, mem_write, branch and jump is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| reg_write_o | output | 1 | Register file write enable |
| reg_dst_rd_o | output | 1 | 1: write to RD (bits 15:11), 0: write to RT (bits 20:16) |
| alu_src_imm_o | output | 1 | 1: second ALU operand is imm_ext, 0: register RT |
| alu_op_o | output | 3 | ALU operation code |
| mem_read_o | output | 1 | Data memory read strobe |
| mem_write_o | output | 1 | Data memory write strobe |
| mem_to_reg_o | output | 1 | 1: write back memory data, 0: ALU result |
| branch_o | output | 1 | Branch-on-equal instruction |
| jump_o | output | 1 | Jump instruction |
| illegal_o | output | 1 | Unsupported encoding |
| imm_ext_o | output | 32 | Sign-extended low 16 bits |

## Verification
The hardest case to reach is a register-format word whose opcode is legal but whose function code is not. Uniform random words almost never have opcode 000000, and the function space is mostly unused. The stimulus therefore picks the opcode from the legal list most of the time. For opcode 000000 it draws function codes from both the legal set and a small band around it (110111, 101111, 000000). It also fills bits 25:6 with random data, so any leak of the register fields into the decode shows up against the bench's model.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int IMM_W   = 16;
    localparam int ALUOP_W = 3;
    localparam int OPC_LSB = XLEN - OPC_W;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_NOR = 3'd4,
        ALU_SLL = 3'd5,
        ALU_SRL = 3'd6
    } alu_op_e;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'b001001;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b010000;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b010001;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'b000010;

    localparam logic [FN_W-1:0] FN_ADD = 6'b110000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b110001;
    localparam logic [FN_W-1:0] FN_AND = 6'b110010;
    localparam logic [FN_W-1:0] FN_OR  = 6'b110011;
    localparam logic [FN_W-1:0] FN_NOR = 6'b110100;
    localparam logic [FN_W-1:0] FN_SLL = 6'b110101;
    localparam logic [FN_W-1:0] FN_SRL = 6'b110110;

    typedef struct packed {
        logic    reg_write;
        logic    dst_rd;
        logic    src_imm;
        alu_op_e alu_op;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;
        logic    branch;
        logic    jump;
    } ctrl_t;

    localparam ctrl_t CTRL_NONE = '0;

endpackage

// File: rtl/opcode_decode.sv
module opcode_decode
    import dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output ctrl_t            ctrl_o,
    output logic             is_reg_o,
    output logic             known_o
);

    always_comb begin
        ctrl_o   = CTRL_NONE;
        is_reg_o = 1'b0;
        known_o  = 1'b1;
        unique case (opc_i)
            OPC_REG: begin
                is_reg_o         = 1'b1;
                ctrl_o.reg_write = 1'b1;
                ctrl_o.dst_rd    = 1'b1;
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI: begin
                ctrl_o.reg_write = 1'b1;
                ctrl_o.src_imm   = 1'b1;
                ctrl_o.alu_op    = (opc_i == OPC_ANDI) ? ALU_AND :
                                   (opc_i == OPC_ORI)  ? ALU_OR  : ALU_ADD;
            end
            OPC_LOAD: begin
                ctrl_o.reg_write  = 1'b1;
                ctrl_o.src_imm    = 1'b1;
                ctrl_o.mem_read   = 1'b1;
                ctrl_o.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl_o.src_imm   = 1'b1;
                ctrl_o.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.branch = 1'b1;
                ctrl_o.alu_op = ALU_SUB;
            end
            OPC_JMP: begin
                ctrl_o.jump = 1'b1;
            end
            default: begin
                known_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/funct_decode.sv
module funct_decode
    import dec_pkg::*;
(
    input  logic [FN_W-1:0] fn_i,
    output alu_op_e         op_o,
    output logic            known_o
);

    always_comb begin
        known_o = 1'b1;
        unique case (fn_i)
            FN_ADD:  op_o = ALU_ADD;
            FN_SUB:  op_o = ALU_SUB;
            FN_AND:  op_o = ALU_AND;
            FN_OR:   op_o = ALU_OR;
            FN_NOR:  op_o = ALU_NOR;
            FN_SLL:  op_o = ALU_SLL;
            FN_SRL:  op_o = ALU_SRL;
            default: begin
                op_o    = ALU_ADD;
                known_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/imm_extend.sv
module imm_extend #(
    parameter int IN_W    = 16,
    parameter int OUT_W   = 32,
    parameter bit SIGNED  = 1'b1
) (
    input  logic [IN_W-1:0]  imm_i,
    output logic [OUT_W-1:0] ext_o
);

    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (SIGNED) begin : g_sign
            assign ext_o = {{PAD_W{imm_i[IN_W-1]}}, imm_i};
        end else begin : g_zero
            assign ext_o = {{PAD_W{1'b0}}, imm_i};
        end
    endgenerate

endmodule

// File: rtl/instr_ctrl_decode.sv
module instr_ctrl_decode
    import dec_pkg::*;
(
    input  logic [XLEN-1:0]    instr_i,
    output logic               reg_write_o,
    output logic               reg_dst_rd_o,
    output logic               alu_src_imm_o,
    output logic [ALUOP_W-1:0] alu_op_o,
    output logic               mem_read_o,
    output logic               mem_write_o,
    output logic               mem_to_reg_o,
    output logic               branch_o,
    output logic               jump_o,
    output logic               illegal_o,
    output logic [XLEN-1:0]    imm_ext_o
);

    ctrl_t   opc_ctrl;
    logic    opc_is_reg;
    logic    opc_known;
    alu_op_e fn_op;
    logic    fn_known;
    ctrl_t   ctrl_d;
    logic    illegal_d;

    opcode_decode u_opc (
        .opc_i    (instr_i[XLEN-1:OPC_LSB]),
        .ctrl_o   (opc_ctrl),
        .is_reg_o (opc_is_reg),
        .known_o  (opc_known)
    );

    funct_decode u_fn (
        .fn_i    (instr_i[FN_W-1:0]),
        .op_o    (fn_op),
        .known_o (fn_known)
    );

    imm_extend #(
        .IN_W   (IMM_W),
        .OUT_W  (XLEN),
        .SIGNED (1'b1)
    ) u_imm (
        .imm_i (instr_i[IMM_W-1:0]),
        .ext_o (imm_ext_o)
    );

    always_comb begin
        illegal_d = !opc_known || (opc_is_reg && !fn_known);
        ctrl_d    = opc_ctrl;
        if (opc_is_reg) begin
            ctrl_d.alu_op = fn_op;
        end
        if (illegal_d) begin
            ctrl_d = CTRL_NONE;
        end
    end

    assign reg_write_o   = ctrl_d.reg_write;
    assign reg_dst_rd_o  = ctrl_d.dst_rd;
    assign alu_src_imm_o = ctrl_d.src_imm;
    assign alu_op_o      = ctrl_d.alu_op;
    assign mem_read_o    = ctrl_d.mem_read;
    assign mem_write_o   = ctrl_d.mem_write;
    assign mem_to_reg_o  = ctrl_d.mem_to_reg;
    assign branch_o      = ctrl_d.branch;
    assign jump_o        = ctrl_d.jump;
    assign illegal_o     = illegal_d;

endmodule

// File: rtl/instr_ctrl_decode_chk.sv
module instr_ctrl_decode_chk
    import dec_pkg::*;
(
    input logic [XLEN-1:0]    instr_i,
    input logic               reg_write_o,
    input logic               reg_dst_rd_o,
    input logic               alu_src_imm_o,
    input logic [ALUOP_W-1:0] alu_op_o,
    input logic               mem_read_o,
    input logic               mem_write_o,
    input logic               mem_to_reg_o,
    input logic               branch_o,
    input logic               jump_o,
    input logic               illegal_o,
    input logic [XLEN-1:0]    imm_ext_o
);

    always_comb begin
        assert_illegal_quiet_R8: assert (!illegal_o ||
            !(reg_write_o || mem_write_o || mem_read_o || branch_o || jump_o))
            else $error("illegal word left a control output high");
        assert_single_action_R11: assert ($onehot0({mem_read_o, mem_write_o, branch_o, jump_o}))
            else $error("more than one memory/flow action");
        assert_store_no_wb_R5: assert (!mem_write_o || (!reg_write_o && alu_src_imm_o && alu_op_o == 3'd0))
            else $error("store control inconsistent");
        assert_load_addr_R4: assert (!mem_read_o || (alu_src_imm_o && alu_op_o == 3'd0 && mem_to_reg_o))
            else $error("load control inconsistent");
        assert_branch_sub_R6: assert (!branch_o || (alu_op_o == 3'd1 && !alu_src_imm_o && !reg_write_o))
            else $error("branch control inconsistent");
        assert_rd_only_reg_R1: assert (!reg_dst_rd_o || instr_i[XLEN-1:OPC_LSB] == OPC_REG)
            else $error("RD destination on non-register format");
        assert_sign_ext_R9: assert (imm_ext_o[XLEN-1:IMM_W] == {(XLEN-IMM_W){instr_i[IMM_W-1]}}
                                    && imm_ext_o[IMM_W-1:0] == instr_i[IMM_W-1:0])
            else $error("immediate extension wrong");
    end

endmodule

bind instr_ctrl_decode instr_ctrl_decode_chk u_chk (.*);

// File: tb/tb_instr_ctrl_decode.sv
`timescale 1ns/1ps
module tb_instr_ctrl_decode;

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic        reg_write, reg_dst_rd, alu_src_imm, mem_read, mem_write;
    logic        mem_to_reg, branch, jump, illegal;
    logic [2:0]  alu_op;
    logic [31:0] imm_ext;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    instr_ctrl_decode dut (
        .instr_i       (instr),
        .reg_write_o   (reg_write),
        .reg_dst_rd_o  (reg_dst_rd),
        .alu_src_imm_o (alu_src_imm),
        .alu_op_o      (alu_op),
        .mem_read_o    (mem_read),
        .mem_write_o   (mem_write),
        .mem_to_reg_o  (mem_to_reg),
        .branch_o      (branch),
        .jump_o        (jump),
        .illegal_o     (illegal),
        .imm_ext_o     (imm_ext)
    );

    // packing: {illegal, reg_write, dst_rd, src_imm, alu_op[2:0], mem_read, mem_write, mem_to_reg, branch, jump}
    function automatic logic [11:0] pack(input logic il, rw, rd, si, input logic [2:0] op,
                                         input logic mr, mw, m2r, br, j);
        return {il, rw, rd, si, op, mr, mw, m2r, br, j};
    endfunction

    function automatic logic [11:0] model(input logic [31:0] w);
        logic [5:0] opc;
        logic [5:0] fn;
        opc = w[31:26];
        fn  = w[5:0];
        case (opc)
            6'b000000: begin
                if (fn >= 6'b110000 && fn <= 6'b110110)
                    return pack(0, 1, 1, 0, 3'(fn - 6'b110000), 0, 0, 0, 0, 0);
                return pack(1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0);
            end
            6'b001000: return pack(0, 1, 0, 1, 3'd0, 0, 0, 0, 0, 0);
            6'b001001: return pack(0, 1, 0, 1, 3'd2, 0, 0, 0, 0, 0);
            6'b001010: return pack(0, 1, 0, 1, 3'd3, 0, 0, 0, 0, 0);
            6'b010000: return pack(0, 1, 0, 1, 3'd0, 1, 0, 1, 0, 0);
            6'b010001: return pack(0, 0, 0, 1, 3'd0, 0, 1, 0, 0, 0);
            6'b000100: return pack(0, 0, 0, 0, 3'd1, 0, 0, 0, 1, 0);
            6'b000010: return pack(0, 0, 0, 0, 3'd0, 0, 0, 0, 0, 1);
            default:   return pack(1, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0);
        endcase
    endfunction

    function automatic string req_of(input logic [31:0] w);
        logic [11:0] m;
        m = model(w);
        if (m[11]) return "R8";
        case (w[31:26])
            6'b000000: return "R1/R2";
            6'b010000: return "R4";
            6'b010001: return "R5";
            6'b000100: return "R6";
            6'b000010: return "R7";
            default:   return "R3";
        endcase
    endfunction

    function automatic logic [11:0] got();
        return {illegal, reg_write, reg_dst_rd, alu_src_imm, alu_op,
                mem_read, mem_write, mem_to_reg, branch, jump};
    endfunction

    task automatic apply_check(input logic [31:0] w);
        logic [11:0] exp_c;
        logic [31:0] exp_i;
        @(negedge clk);
        instr = w;
        #1;
        exp_c = model(w);
        exp_i = {{16{w[15]}}, w[15:0]};
        checks++;
        if (got() !== exp_c) begin
            failures++;
            $display("FAIL %s instr=%h ctrl got=%b exp=%b", req_of(w), w, got(), exp_c);
        end
        checks++;
        if (imm_ext !== exp_i) begin
            failures++;
            $display("FAIL R9 instr=%h imm_ext got=%h exp=%h", w, imm_ext, exp_i);
        end
        checks++;
        if ($countones({mem_read, mem_write, branch, jump}) > 1) begin
            failures++;
            $display("FAIL R11 instr=%h actions got=%b exp=at most one set", w,
                     {mem_read, mem_write, branch, jump});
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [19:0] mid,
                                       input logic [5:0] fn);
        return {opc, mid, fn};
    endfunction

    localparam logic [5:0] LEGAL_OPC [8] = '{6'b000000, 6'b001000, 6'b001001, 6'b001010,
                                             6'b010000, 6'b010001, 6'b000100, 6'b000010};

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired got=running exp=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [11:0] ref_c;
        void'($urandom(32'd20240611));
        instr = 32'h0;

        // R1 R2: every function code of the register format
        for (int f = 0; f < 7; f++) apply_check(mk(6'b000000, 20'h1A2B3, 6'(6'b110000 + f)));
        // R3 R4 R5 R6 R7: each immediate/flow opcode, both immediate signs
        for (int i = 1; i < 8; i++) begin
            apply_check(mk(LEGAL_OPC[i], 20'h00000, 6'h01));
            apply_check(mk(LEGAL_OPC[i], 20'hFFFFF, 6'h3F));
        end
        // R8: unknown opcodes and unknown function codes next to the legal band
        apply_check(32'hFFFF_FFFF);
        apply_check(mk(6'b000001, 20'h0, 6'b110000));
        apply_check(mk(6'b000011, 20'h0, 6'b110000));
        apply_check(mk(6'b000000, 20'h0, 6'b110111));
        apply_check(mk(6'b000000, 20'h0, 6'b101111));
        apply_check(mk(6'b000000, 20'h0, 6'b000000));

        // R10: register fields do not change the decode
        for (int k = 0; k < 8; k++) begin
            logic [31:0] w;
            w = mk(LEGAL_OPC[k], 20'h0, 6'b110100);
            apply_check(w);
            ref_c = got();
            apply_check({w[31:26], 20'($urandom), w[5:0]});
            checks++;
            if (got() !== ref_c) begin
                failures++;
                $display("FAIL R10 opc=%b ctrl got=%b exp=%b", w[31:26], got(), ref_c);
            end
        end

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [5:0] opc;
            logic [5:0] fn;
            int sel;
            sel = int'($urandom % 10);
            opc = (sel < 8) ? LEGAL_OPC[sel] : 6'($urandom);
            if (opc == 6'b000000 && ($urandom % 4) != 0)
                fn = 6'(6'b110000 + ($urandom % 8));
            else
                fn = 6'($urandom);
            apply_check(mk(opc, 20'($urandom), fn));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule